// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of an in-order core and picks the address it moves to at every rising clock edge. Each cycle the decoder presents a branch kind, a 4-bit condition code, two raw branch offset fields (a long one for unconditional branches and a short one for conditional branches) and the current N, Z, C and V flags. The unit sign-extends the chosen offset, scales it by the instruction size of four bytes, and adds it to the current PC. If no branch is taken, the PC steps to the next instruction.

The block also drives a link value equal to the current PC plus four. For a branch-and-link it raises a write strobe and gives the index of the link register, 30, so that the register file can capture the return address in the same cycle that the PC is redirected. A stall input freezes the PC and suppresses the link write. The PC register is the only state. Each cycle a small decision stage picks one of four next-address selections: SEQ (step by four), FAR (long offset), NEAR (short offset) or HOLD (stall). The PC register then moves according to that selection. Reset moves it to zero.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_n is low the PC is forced to 0 at once, without waiting for a clock edge, and link_we_o is 0.
- R2: With br_kind_i = 0 (no branch) and no stall, each rising edge loads PC + 4.
- R3: With br_kind_i = 1 (unconditional) and no stall, the edge loads PC + SignExtend(imm_long_i) × 4.
- R4: With br_kind_i = 2 (conditional) and no stall, the edge loads PC + SignExtend(imm_short_i) × 4 if the condition holds, and PC + 4 otherwise.
- R5: The condition codes are evaluated as follows: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !(C&!Z); 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 !(!Z&(N==V)); 14 and 15 always true.
- R6: With br_kind_i = 3 (branch-and-link) and no stall, link_we_o is 1 in that cycle, link_idx_o is 30, and the edge loads PC + SignExtend(imm_long_i) × 4.
- R7: While stall_i is 1 the PC keeps its value for any branch kind, and link_we_o is 0.
- R8: All address arithmetic wraps modulo 2^64, both below zero and past the top of the address space.
- R9: link_o always equals the current PC + 4, whatever the branch kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold the PC and block the link write |
| br_kind_i | input | 2 | 0 none, 1 unconditional, 2 conditional, 3 branch-and-link |
| cond_i | input | 4 | Condition code for conditional branches |
| imm_long_i | input | 26 | Signed word offset for kinds 1 and 3 |
| imm_short_i | input | 19 | Signed word offset for kind 2 |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| pc_o | output | 64 | Current program counter |
| link_o | output | 64 | Return address, PC + 4 |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Link register index (30) |

## Verification
Conditional branches are swept over all 16 condition codes crossed with all 16 flag combinations. Each pair both decides taken against not-taken and produces a distinct offset, so a wrong entry in the condition table shows up as a wrong next PC. The unconditional and link branches are driven with zero, small, largest positive and most negative offsets, which separates correct sign extension and scaling from truncation. A backward jump from zero and a step past the top of the address space confirm the wrap. Stall cycles mixed with every branch kind separate holding the PC from following a branch, and confirm that the link strobe stays low while stalled.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        BR_NONE   = 2'd0,
        BR_UNCOND = 2'd1,
        BR_COND   = 2'd2,
        BR_LINK   = 2'd3
    } br_kind_t;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_t;

    typedef enum logic [1:0] {
        NXT_SEQ  = 2'd0,
        NXT_FAR  = 2'd1,
        NXT_NEAR = 2'd2,
        NXT_HOLD = 2'd3
    } nxt_sel_t;

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic       n_i,
    input  logic       z_i,
    input  logic       c_i,
    input  logic       v_i,
    output logic       pass_o
);

    cond_t code;
    assign code = cond_t'(cond_i);

    always_comb begin
        unique case (code)
            CC_EQ:   pass_o = z_i;
            CC_NE:   pass_o = !z_i;
            CC_CS:   pass_o = c_i;
            CC_CC:   pass_o = !c_i;
            CC_MI:   pass_o = n_i;
            CC_PL:   pass_o = !n_i;
            CC_VS:   pass_o = v_i;
            CC_VC:   pass_o = !v_i;
            CC_HI:   pass_o = c_i && !z_i;
            CC_LS:   pass_o = !c_i || z_i;
            CC_GE:   pass_o = (n_i == v_i);
            CC_LT:   pass_o = (n_i != v_i);
            CC_GT:   pass_o = !z_i && (n_i == v_i);
            CC_LE:   pass_o = z_i || (n_i != v_i);
            CC_AL:   pass_o = 1'b1;
            CC_NV:   pass_o = 1'b1;
            default: pass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcseq_offset.sv
module pcseq_offset #(
    parameter int IMM_W  = 26,
    parameter int ADDR_W = 64,
    parameter int SHIFT  = 2
) (
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] off_o
);

    localparam int PAD = ADDR_W - IMM_W - SHIFT;

    generate
        if (SHIFT == 0) begin : g_noscale
            assign off_o = {{PAD{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_scale
            assign off_o = {{PAD{imm_i[IMM_W-1]}}, imm_i, {SHIFT{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
    import pcseq_pkg::*;
(
    input  logic       stall_i,
    input  logic [1:0] kind_i,
    input  logic       pass_i,
    output nxt_sel_t   sel_o,
    output logic       link_we_o
);

    br_kind_t kind;
    assign kind = br_kind_t'(kind_i);

    always_comb begin
        sel_o     = NXT_SEQ;
        link_we_o = 1'b0;
        if (stall_i) begin
            sel_o = NXT_HOLD;
        end else begin
            unique case (kind)
                BR_NONE:   sel_o = NXT_SEQ;
                BR_UNCOND: sel_o = NXT_FAR;
                BR_COND:   sel_o = pass_i ? NXT_NEAR : NXT_SEQ;
                BR_LINK: begin
                    sel_o     = NXT_FAR;
                    link_we_o = 1'b1;
                end
                default:   sel_o = NXT_SEQ;
            endcase
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int IMM_LONG_W  = 26,
    parameter int IMM_SHORT_W = 19,
    parameter int INSN_BYTES  = 4,
    parameter int REG_IDX_W   = 5,
    parameter int LINK_REG    = 30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall_i,
    input  logic [1:0]             br_kind_i,
    input  logic [3:0]             cond_i,
    input  logic [IMM_LONG_W-1:0]  imm_long_i,
    input  logic [IMM_SHORT_W-1:0] imm_short_i,
    input  logic                   flag_n_i,
    input  logic                   flag_z_i,
    input  logic                   flag_c_i,
    input  logic                   flag_v_i,
    output logic [ADDR_W-1:0]      pc_o,
    output logic [ADDR_W-1:0]      link_o,
    output logic                   link_we_o,
    output logic [REG_IDX_W-1:0]   link_idx_o
);

    localparam int SHIFT = $clog2(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] off_far;
    logic [ADDR_W-1:0] off_near;
    logic [ADDR_W-1:0] seq_addr;
    logic              pass;
    logic              we_raw;
    nxt_sel_t          sel;

    pcseq_cond u_cond (
        .cond_i (cond_i),
        .n_i    (flag_n_i),
        .z_i    (flag_z_i),
        .c_i    (flag_c_i),
        .v_i    (flag_v_i),
        .pass_o (pass)
    );

    pcseq_offset #(.IMM_W(IMM_LONG_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_off_far (
        .imm_i (imm_long_i),
        .off_o (off_far)
    );

    pcseq_offset #(.IMM_W(IMM_SHORT_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_off_near (
        .imm_i (imm_short_i),
        .off_o (off_near)
    );

    pcseq_select u_sel (
        .stall_i   (stall_i),
        .kind_i    (br_kind_i),
        .pass_i    (pass),
        .sel_o     (sel),
        .link_we_o (we_raw)
    );

    assign seq_addr = pc_q + STEP;

    // next-address decision
    always_comb begin
        unique case (sel)
            NXT_SEQ:  pc_d = seq_addr;
            NXT_FAR:  pc_d = pc_q + off_far;
            NXT_NEAR: pc_d = pc_q + off_near;
            NXT_HOLD: pc_d = pc_q;
            default:  pc_d = pc_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // outputs
    always_comb begin
        pc_o       = pc_q;
        link_o     = seq_addr;
        link_we_o  = we_raw && rst_n;
        link_idx_o = REG_IDX_W'(LINK_REG);
    end

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int ADDR_W      = 64,
    parameter int IMM_LONG_W  = 26,
    parameter int IMM_SHORT_W = 19
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   stall_i,
    input logic [1:0]             br_kind_i,
    input logic [3:0]             cond_i,
    input logic [IMM_LONG_W-1:0]  imm_long_i,
    input logic [IMM_SHORT_W-1:0] imm_short_i,
    input logic [ADDR_W-1:0]      pc_o,
    input logic                   link_we_o
);

    logic [ADDR_W-1:0] far_step;
    logic [ADDR_W-1:0] near_step;
    assign far_step  = ADDR_W'($signed(imm_long_i)) <<< 2;
    assign near_step = ADDR_W'($signed(imm_short_i)) <<< 2;

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && br_kind_i == 2'd0) |=> pc_o == $past(pc_o) + ADDR_W'(4));

    a_r3_far_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && br_kind_i == 2'd1) |=> pc_o == $past(pc_o) + $past(far_step));

    a_r4_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && br_kind_i == 2'd2 && cond_i == 4'd14) |=> pc_o == $past(pc_o) + $past(near_step));

    a_r6_link_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (br_kind_i == 2'd3 && !stall_i));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(pc_o));

endmodule

bind pc_sequencer pcseq_checker #(
    .ADDR_W      (ADDR_W),
    .IMM_LONG_W  (IMM_LONG_W),
    .IMM_SHORT_W (IMM_SHORT_W)
) u_pcseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .br_kind_i   (br_kind_i),
    .cond_i      (cond_i),
    .imm_long_i  (imm_long_i),
    .imm_short_i (imm_short_i),
    .pc_o        (pc_o),
    .link_we_o   (link_we_o)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall_i;
    logic [1:0]  br_kind_i;
    logic [3:0]  cond_i;
    logic [25:0] imm_long_i;
    logic [18:0] imm_short_i;
    logic        flag_n_i, flag_z_i, flag_c_i, flag_v_i;
    logic [63:0] pc_o;
    logic [63:0] link_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;
    logic [63:0] exp_pc   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_i     (stall_i),
        .br_kind_i   (br_kind_i),
        .cond_i      (cond_i),
        .imm_long_i  (imm_long_i),
        .imm_short_i (imm_short_i),
        .flag_n_i    (flag_n_i),
        .flag_z_i    (flag_z_i),
        .flag_c_i    (flag_c_i),
        .flag_v_i    (flag_v_i),
        .pc_o        (pc_o),
        .link_o      (link_o),
        .link_we_o   (link_we_o),
        .link_idx_o  (link_idx_o)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, expv);
        end
    endtask

    // condition truth derived from pairs: even code tests, odd code inverts
    function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] nzcv);
        bit n = nzcv[3], z = nzcv[2], c = nzcv[1], v = nzcv[0];
        bit base;
        case (cc[3:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c && !z;
            3'd5: base = (n == v);
            3'd6: base = !z && (n == v);
            default: base = 1'b1;
        endcase
        if (cc[3:1] != 3'd7 && cc[0]) base = !base;
        return base;
    endfunction

    // called just after a falling edge; returns just after the next falling edge
    task automatic step(input logic [1:0] k, input logic [3:0] cc, input logic [25:0] il,
                        input logic [18:0] is, input logic [3:0] nzcv, input logic st,
                        input string rq);
        logic [63:0] nxt;
        br_kind_i   = k;
        cond_i      = cc;
        imm_long_i  = il;
        imm_short_i = is;
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = nzcv;
        stall_i     = st;
        #1;
        chk("R9 link value", link_o, exp_pc + 64'd4);
        chk({rq, " R6 R7 link strobe"}, {63'd0, link_we_o}, {63'd0, (k == 2'd3 && !st)});
        if (st)                                   nxt = exp_pc;
        else if (k == 2'd1 || k == 2'd3)          nxt = exp_pc + 64'(longint'($signed(il)) * 4);
        else if (k == 2'd2 && cond_ok(cc, nzcv))  nxt = exp_pc + 64'(longint'($signed(is)) * 4);
        else                                      nxt = exp_pc + 64'd4;
        @(posedge clk);
        #1;
        exp_pc = nxt;
        chk({rq, " next pc"}, pc_o, exp_pc);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        stall_i = 1'b0; br_kind_i = 2'd0; cond_i = 4'd0;
        imm_long_i = '0; imm_short_i = '0;
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = 4'd0;
        br_kind_i = 2'd3;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset pc", pc_o, 64'd0);
        chk("R1 link strobe in reset", {63'd0, link_we_o}, 64'd0);
        chk("R9 link in reset", link_o, 64'd4);
        br_kind_i = 2'd0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2 sequential
        for (int i = 0; i < 4; i++) step(2'd0, 4'd0, '0, '0, 4'd0, 1'b0, "R2");

        // R3 unconditional with boundary offsets
        step(2'd1, 4'd0, 26'd5,         '0, 4'd0, 1'b0, "R3 small");
        step(2'd1, 4'd0, 26'h3FFFFFD,   '0, 4'd0, 1'b0, "R3 negative");
        step(2'd1, 4'd0, 26'h1FFFFFF,   '0, 4'd0, 1'b0, "R3 max positive");
        step(2'd1, 4'd0, 26'h2000000,   '0, 4'd0, 1'b0, "R3 most negative");
        step(2'd1, 4'd0, 26'd0,         '0, 4'd0, 1'b0, "R3 zero");

        // R1 asynchronous reset mid-cycle
        #2 rst_n = 1'b0;
        #1;
        exp_pc = '0;
        chk("R1 async reset pc", pc_o, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 wrap below zero and past the top
        step(2'd1, 4'd0, 26'h3FFFFFF, '0, 4'd0, 1'b0, "R8 below zero");
        chk("R8 wrapped high", pc_o, 64'hFFFF_FFFF_FFFF_FFFC);
        step(2'd0, 4'd0, '0, '0, 4'd0, 1'b0, "R8 past top");
        chk("R8 wrapped to zero", pc_o, 64'd0);

        // R4 R5 full cross of condition codes and flags
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                logic [18:0] off;
                off = 19'(cc * 37 + f * 1001);
                if (f[0]) off = off | 19'h40000;
                step(2'd2, 4'(cc), 26'h155, off, 4'(f), 1'b0, "R4 R5 cond branch");
            end
        end
        step(2'd2, 4'd14, '0, 19'h40000, 4'd0, 1'b0, "R4 most negative near");
        step(2'd2, 4'd14, '0, 19'h3FFFF, 4'd0, 1'b0, "R4 max positive near");

        // R6 branch and link
        step(2'd3, 4'd0, 26'd100, '0, 4'd0, 1'b0, "R6 link fwd");
        step(2'd3, 4'd0, 26'h3FFFF00, '0, 4'd0, 1'b0, "R6 link back");
        chk("R6 link index", {59'd0, link_idx_o}, 64'd30);

        // R7 stall with every kind
        for (int k = 0; k < 4; k++) begin
            step(2'(k), 4'd14, 26'd77, 19'd9, 4'd0, 1'b1, "R7 stall");
        end
        step(2'd0, 4'd0, '0, '0, 4'd0, 1'b0, "R7 resume");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule